// File: doc/BRIEF.md
# Credit-Gated Virtual Output Queue Scheduler

This block sorts packet descriptors by destination into one virtual output queue (VOQ) per output port. It also keeps one shared queue for multicast descriptors that are copied on the far side of the switch. A queued descriptor crosses a small crossbar only when the output queue it targets has a free slot that has not yet been promised to another descriptor. Each output queue advertises one credit for every such slot. The credit is spent when a descriptor crosses, and it is advertised again when the output queue hands a descriptor onward to buffer readout.

Multicast is handled in two ways, chosen per descriptor by `in_mode`. With `in_mode = 0`, the block replicates on the ingress side: it walks the destination bitmap and places one copy in each addressed VOQ. With `in_mode = 1`, the block replicates on the egress side: the descriptor is queued once and copied into every addressed output queue as it crosses. A unicast descriptor is the ingress case with exactly one bit set.

The descriptor input follows valid/ready rules. Once `in_valid` is high, the source holds the descriptor stable until a cycle in which `in_ready` is also high, and the transfer happens at that clock edge. Back-pressure comes only from full queues, and no descriptor is ever discarded. Each output port is also valid/ready. `out_valid` and `out_desc` hold until `out_ready` takes the descriptor.

Top module: `voq_credit_sched`

## Requirements
- R1: After reset, no output port is valid, every `crd_avail` bit is 1 (each output queue holds OQ_DEPTH credits), and every `crd_req` bit is 0.
- R2: A unicast descriptor (in_mode 0, one bitmap bit set) with an empty VOQ and credit available is accepted in its first valid cycle. It appears on its port two clock edges after acceptance, and not earlier.
- R3: A descriptor crosses to output d only when d holds a credit. Credits start at OQ_DEPTH, drop by one per descriptor sent to d, and rise by one per descriptor dequeued from d. `crd_avail[d]` is 1 exactly when d holds a credit. `crd_req[d]` is 1 when a queued head descriptor targets d.
- R4: At most one VOQ crosses the crossbar per cycle. When several VOQs are eligible, a round-robin arbiter picks one, and every eligible VOQ is served within a number of cycles equal to the VOQ count.
- R5: Ingress replication (in_mode 0) enqueues one copy per clock, from the lowest set bitmap bit to the highest. `in_ready` rises only in the cycle of the last copy, so a map with k set bits takes k cycles. Every addressed port receives the descriptor.
- R6: Egress replication (in_mode 1) is accepted in one cycle into the multicast queue. It crosses only when every addressed output holds a credit, and then it lands in all addressed output queues on the same edge, two edges after acceptance.
- R7: When the VOQ a descriptor needs is full, `in_ready` stays 0 and the descriptor waits. No descriptor is dropped, and each port delivers its descriptors in arrival order.
- R8: A descriptor with an all-zero bitmap is accepted in one cycle and produces no output on any port.
- R9: While `out_valid[d]` is 1 and `out_ready[d]` is 0, the port keeps `out_valid[d]` and its descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor taken at this edge when in_valid is high |
| in_mode | input | 1 | 0: ingress replication or unicast, 1: egress replication |
| in_dmap | input | N_OUT | Destination bitmap, bit d selects output port d |
| in_desc | input | DW | Descriptor contents |
| out_valid | output | N_OUT | Output port d holds a descriptor |
| out_ready | input | N_OUT | Output port d takes its descriptor |
| out_desc | output | N_OUT*DW | Descriptor of port d in bits d*DW +: DW |
| crd_req | output | N_OUT | A queued head descriptor wants credit from output d |
| crd_avail | output | N_OUT | Output d holds at least one credit |

## Verification
A descriptor is written into its VOQ at the acceptance edge, crosses at the next edge, and is visible on its port after the second. The bench therefore checks one negative edge after acceptance that nothing is valid yet, and checks the second negative edge for the exact port set. Ingress walks are timed by counting the valid cycles before `in_ready`, which must equal the bitmap's popcount. After a dequeue, credit returns at that same edge and the waiting descriptor crosses one edge later. In the round-robin case, the bench checks `crd_req` and `crd_avail` on the negative edges that follow, so that only one crossing is seen per cycle.

// File: rtl/vsch_pkg.sv
package vsch_pkg;
  localparam logic MODE_INGRESS = 1'b0;
  localparam logic MODE_EGRESS  = 1'b1;
endpackage

// File: rtl/vsch_fifo.sv
module vsch_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R7: queues are never written while full (nothing is silently lost)
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: reads only happen from a non-empty queue
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/vsch_ingress.sv
module vsch_ingress #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic [N_OUT-1:0] in_dmap,
  input  logic [N_OUT-1:0] voq_full,
  input  logic             mq_full,
  output logic             in_ready,
  output logic [N_OUT-1:0] voq_push,
  output logic             mq_push
);
  logic [N_OUT-1:0] done_q, remain, lo_oh, rest;
  logic             step;

  assign remain = in_dmap & ~done_q;
  assign lo_oh  = remain & (~remain + 1'b1);
  assign rest   = remain & ~lo_oh;

  always_comb begin
    voq_push = '0;
    mq_push  = 1'b0;
    in_ready = 1'b0;
    step     = 1'b0;
    if (in_mode == vsch_pkg::MODE_EGRESS) begin
      in_ready = !mq_full;
      mq_push  = in_valid && !mq_full;
    end else if (remain == '0) begin
      in_ready = 1'b1;
    end else if ((lo_oh & voq_full) == '0) begin
      voq_push = in_valid ? lo_oh : '0;
      step     = in_valid;
      in_ready = (rest == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    done_q <= '0;
    else if (in_valid && in_ready) done_q <= '0;
    else if (step)                 done_q <= done_q | lo_oh;
  end

  // R5: the walk places at most one copy per cycle
  a_r5_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(voq_push));
  // R5: a copy already placed is never placed again for the same descriptor
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (voq_push & done_q) == '0);
endmodule

// File: rtl/vsch_xbar_sched.sv
module vsch_xbar_sched #(
  parameter int N_OUT    = 4,
  parameter int DW       = 8,
  parameter int OQ_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_OUT-1:0]    voq_empty,
  input  logic [N_OUT*DW-1:0] voq_heads,
  input  logic                mq_empty,
  input  logic [N_OUT-1:0]    mq_map,
  input  logic [DW-1:0]       mq_desc,
  input  logic [N_OUT-1:0]    oq_pop,
  output logic [N_OUT-1:0]    voq_pop,
  output logic                mq_pop,
  output logic [N_OUT-1:0]    oq_push,
  output logic [DW-1:0]       oq_din,
  output logic [N_OUT-1:0]    crd_req,
  output logic [N_OUT-1:0]    crd_avail
);
  localparam int NQ  = N_OUT + 1;
  localparam int QW  = $clog2(NQ);
  localparam int CRW = $clog2(OQ_DEPTH + 1);

  logic [CRW-1:0] credit [N_OUT];
  logic [NQ-1:0]  elig;
  logic [QW-1:0]  ptr_q, win;
  logic           win_vld;
  logic [DW-1:0]  uc_sel;

  for (genvar d = 0; d < N_OUT; d++) begin : g_crd
    assign crd_avail[d] = (credit[d] != '0);
    assign crd_req[d]   = !voq_empty[d] || (!mq_empty && mq_map[d]);
    assign elig[d]      = !voq_empty[d] && crd_avail[d];

    always_ff @(posedge clk) begin
      if (!rst_n) credit[d] <= CRW'(OQ_DEPTH);
      else        credit[d] <= credit[d] - CRW'(oq_push[d]) + CRW'(oq_pop[d]);
    end

    // R3: the credit count never exceeds the output queue depth
    a_r3_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      credit[d] <= CRW'(OQ_DEPTH));
    // R3: nothing crosses to an output that holds no credit
    a_r3_cross_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
      oq_push[d] |-> credit[d] != '0);
  end

  assign elig[N_OUT] = !mq_empty && ((mq_map & ~crd_avail) == '0);

  always_comb begin
    win_vld = 1'b0;
    win     = '0;
    for (int k = 1; k <= NQ; k++) begin
      if (!win_vld && elig[(int'(ptr_q) + k) % NQ]) begin
        win_vld = 1'b1;
        win     = QW'((int'(ptr_q) + k) % NQ);
      end
    end
  end

  always_comb begin
    uc_sel = '0;
    for (int q = 0; q < N_OUT; q++) begin
      voq_pop[q] = win_vld && (win == QW'(q));
      if (win == QW'(q)) uc_sel = voq_heads[q*DW +: DW];
    end
    mq_pop  = win_vld && (win == QW'(N_OUT));
    oq_push = mq_pop ? mq_map : voq_pop;
    oq_din  = mq_pop ? mq_desc : uc_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= QW'(NQ - 1);
    else if (win_vld) ptr_q <= win;
  end

  // R4: at most one queue crosses the crossbar in a cycle
  a_r4_one_crossing: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mq_pop, voq_pop}));
  // R4: whenever any queue is eligible, one of them crosses
  a_r4_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> ({mq_pop, voq_pop} != '0));
endmodule

// File: rtl/voq_credit_sched.sv
module voq_credit_sched #(
  parameter int N_OUT     = 4,
  parameter int DW        = 8,
  parameter int VOQ_DEPTH = 4,
  parameter int OQ_DEPTH  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_mode,
  input  logic [N_OUT-1:0]    in_dmap,
  input  logic [DW-1:0]       in_desc,
  output logic [N_OUT-1:0]    out_valid,
  input  logic [N_OUT-1:0]    out_ready,
  output logic [N_OUT*DW-1:0] out_desc,
  output logic [N_OUT-1:0]    crd_req,
  output logic [N_OUT-1:0]    crd_avail
);
  localparam int MW = N_OUT + DW;

  logic [N_OUT-1:0]    voq_push, voq_pop, voq_full, voq_empty;
  logic [N_OUT*DW-1:0] voq_heads;
  logic                mq_push, mq_pop, mq_full, mq_empty;
  logic [MW-1:0]       mq_head;
  logic [N_OUT-1:0]    oq_push, oq_pop, oq_empty, oq_full;
  logic [DW-1:0]       oq_din;

  vsch_ingress #(.N_OUT(N_OUT)) u_ingress (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .in_dmap  (in_dmap),
    .voq_full (voq_full),
    .mq_full  (mq_full),
    .in_ready (in_ready),
    .voq_push (voq_push),
    .mq_push  (mq_push)
  );

  for (genvar d = 0; d < N_OUT; d++) begin : g_voq
    vsch_fifo #(.W(DW), .DEPTH(VOQ_DEPTH)) u_voq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (voq_push[d]),
      .din   (in_desc),
      .pop   (voq_pop[d]),
      .dout  (voq_heads[d*DW +: DW]),
      .empty (voq_empty[d]),
      .full  (voq_full[d])
    );
  end

  vsch_fifo #(.W(MW), .DEPTH(VOQ_DEPTH)) u_mq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (mq_push),
    .din   ({in_dmap, in_desc}),
    .pop   (mq_pop),
    .dout  (mq_head),
    .empty (mq_empty),
    .full  (mq_full)
  );

  vsch_xbar_sched #(.N_OUT(N_OUT), .DW(DW), .OQ_DEPTH(OQ_DEPTH)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .voq_empty (voq_empty),
    .voq_heads (voq_heads),
    .mq_empty  (mq_empty),
    .mq_map    (mq_head[MW-1:DW]),
    .mq_desc   (mq_head[DW-1:0]),
    .oq_pop    (oq_pop),
    .voq_pop   (voq_pop),
    .mq_pop    (mq_pop),
    .oq_push   (oq_push),
    .oq_din    (oq_din),
    .crd_req   (crd_req),
    .crd_avail (crd_avail)
  );

  for (genvar d = 0; d < N_OUT; d++) begin : g_oq
    vsch_fifo #(.W(DW), .DEPTH(OQ_DEPTH)) u_oq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (oq_push[d]),
      .din   (oq_din),
      .pop   (oq_pop[d]),
      .dout  (out_desc[d*DW +: DW]),
      .empty (oq_empty[d]),
      .full  (oq_full[d])
    );
    assign out_valid[d] = !oq_empty[d];
    assign oq_pop[d]    = out_valid[d] && out_ready[d];

    // R9: a stalled output keeps its descriptor
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[d] && !out_ready[d] |=> out_valid[d] && $stable(out_desc[d*DW +: DW]));
    // R3: an output holding no credit has a full queue until something leaves
    a_r3_no_credit_means_full: assert property (@(posedge clk) disable iff (!rst_n)
      !crd_avail[d] |-> oq_full[d]);
  end
endmodule

// File: tb/voq_credit_sched_tb.sv
module voq_credit_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int VQD = 4;
  localparam int OQD = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_mode = 1'b0;
  logic [N-1:0]    in_dmap = '0;
  logic [DW-1:0]   in_desc = '0;
  logic [N-1:0]    out_valid;
  logic [N-1:0]    out_ready = '0;
  logic [N*DW-1:0] out_desc;
  logic [N-1:0]    crd_req, crd_avail;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voq_credit_sched #(.N_OUT(N), .DW(DW), .VOQ_DEPTH(VQD), .OQ_DEPTH(OQD)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_dmap(in_dmap), .in_desc(in_desc),
    .out_valid(out_valid), .out_ready(out_ready), .out_desc(out_desc),
    .crd_req(crd_req), .crd_avail(crd_avail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] od(input int d);
    return out_desc[d*DW +: DW];
  endfunction

  function automatic int popc(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic send(input logic mode, input logic [N-1:0] map,
                      input logic [DW-1:0] d, output int cyc);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_dmap = map; in_desc = d;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pop_expect(input int d, input logic [DW-1:0] exp, input string req);
    int w = 0;
    @(negedge clk);
    #1;
    while (!out_valid[d] && w < 40) begin
      @(negedge clk);
      #1;
      w++;
    end
    chk(out_valid[d] && od(d) == exp, req, int'(od(d)), int'(exp));
    out_ready[d] = 1'b1;
    @(posedge clk);
    #1 out_ready[d] = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    out_ready = '1;
    repeat (12) @(posedge clk);
    #1 out_ready = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
    chk(crd_avail == '1, "R1 crd_avail", int'(crd_avail), 15);
    chk(crd_req == '0, "R1 crd_req", int'(crd_req), 0);
    rst_n = 1'b1;

    // R2: unicast to every port, exact delivery cycle
    for (int d = 0; d < N; d++) begin
      send(1'b0, N'(1) << d, DW'(8'h10 + d), cyc);
      chk(cyc == 1, "R2 accept cycles", cyc, 1);
      @(negedge clk); #1;
      chk(out_valid == '0, "R2 not early", int'(out_valid), 0);
      @(negedge clk); #1;
      chk(out_valid == (N'(1) << d), "R2 port", int'(out_valid), 1 << d);
      chk(od(d) == DW'(8'h10 + d), "R2 desc", int'(od(d)), 16 + d);
      out_ready[d] = 1'b1;
      @(posedge clk); #1 out_ready[d] = 1'b0;
      @(negedge clk); #1;
      chk(out_valid == '0, "R9 dequeued", int'(out_valid), 0);
    end

    // R5: ingress replication over every non-zero map
    for (int m = 1; m < (1 << N); m++) begin
      send(1'b0, N'(m), DW'(8'h40 + m), cyc);
      chk(cyc == popc(N'(m)), "R5 walk cycles", cyc, popc(N'(m)));
      @(negedge clk); @(negedge clk); #1;
      chk(out_valid == N'(m), "R5 port set", int'(out_valid), m);
      for (int d = 0; d < N; d++)
        if (m[d]) chk(od(d) == DW'(8'h40 + m), "R5 copy desc", int'(od(d)), 64 + m);
      drain();
    end

    // R6: egress replication over every non-zero map
    for (int m = 1; m < (1 << N); m++) begin
      send(1'b1, N'(m), DW'(8'h80 + m), cyc);
      chk(cyc == 1, "R6 accept cycles", cyc, 1);
      @(negedge clk); #1;
      chk(out_valid == '0, "R6 not early", int'(out_valid), 0);
      @(negedge clk); #1;
      chk(out_valid == N'(m), "R6 same-edge copies", int'(out_valid), m);
      for (int d = 0; d < N; d++)
        if (m[d]) chk(od(d) == DW'(8'h80 + m), "R6 copy desc", int'(od(d)), 128 + m);
      drain();
    end

    // R8: empty maps in both modes
    for (int md = 0; md < 2; md++) begin
      send(md[0], '0, 8'hEE, cyc);
      chk(cyc == 1, "R8 accept cycles", cyc, 1);
      repeat (3) @(negedge clk); #1;
      chk(out_valid == '0, "R8 no output", int'(out_valid), 0);
      chk(crd_req == '0, "R8 no request", int'(crd_req), 0);
    end

    // R3 / R7 / R9: credit exhaustion, full VOQ back-pressure, order
    send(1'b0, 4'b0001, 8'hA0, cyc);
    send(1'b0, 4'b0001, 8'hA1, cyc);
    send(1'b0, 4'b0001, 8'hA2, cyc);
    @(negedge clk); @(negedge clk); #1;
    chk(crd_avail[0] == 1'b0, "R3 credit spent", int'(crd_avail[0]), 0);
    chk(crd_req[0] == 1'b1, "R3 request held", int'(crd_req[0]), 1);
    chk(out_valid[0] && od(0) == 8'hA0, "R9 head held", int'(od(0)), 160);
    send(1'b0, 4'b0001, 8'hA3, cyc);
    send(1'b0, 4'b0001, 8'hA4, cyc);
    send(1'b0, 4'b0001, 8'hA5, cyc);
    fork
      send(1'b0, 4'b0001, 8'hA6, cyc);
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R7 ready low when VOQ full", int'(in_ready), 0);
        for (int i = 0; i < 7; i++) pop_expect(0, DW'(8'hA0 + i), "R7 order no drop");
      end
    join
    drain();

    // R6 / R3: egress copy waits for credit at every target
    send(1'b0, 4'b0001, 8'hB0, cyc);
    send(1'b0, 4'b0001, 8'hB1, cyc);
    send(1'b1, 4'b0011, 8'hB2, cyc);
    repeat (3) @(negedge clk); #1;
    chk(out_valid[1] == 1'b0, "R6 waits for all credits", int'(out_valid[1]), 0);
    chk(crd_req[1:0] == 2'b11, "R3 request both", int'(crd_req[1:0]), 3);
    pop_expect(0, 8'hB0, "R6 first old");
    pop_expect(0, 8'hB1, "R6 second old");
    pop_expect(0, 8'hB2, "R6 copy port0");
    pop_expect(1, 8'hB2, "R6 copy port1");
    drain();

    // R4: two VOQs become eligible on the same edge
    send(1'b0, 4'b0001, 8'hC0, cyc);
    send(1'b0, 4'b0001, 8'hC1, cyc);
    send(1'b0, 4'b0010, 8'hD0, cyc);
    send(1'b0, 4'b0010, 8'hD1, cyc);
    send(1'b0, 4'b0001, 8'hC2, cyc);
    send(1'b0, 4'b0010, 8'hD2, cyc);
    repeat (3) @(negedge clk);
    out_ready = 4'b0011;
    @(posedge clk); #1 out_ready = '0;
    @(negedge clk); #1;
    chk(crd_avail[1:0] == 2'b11 && crd_req[1:0] == 2'b11, "R4 both eligible",
        int'({crd_avail[1:0], crd_req[1:0]}), 15);
    @(negedge clk); #1;
    chk(popc({2'b00, crd_req[1:0]}) == 1, "R4 one crossing per cycle", int'(crd_req[1:0]), 1);
    @(negedge clk); #1;
    chk(crd_req[1:0] == 2'b00 && crd_avail[1:0] == 2'b00, "R4 both served",
        int'({crd_avail[1:0], crd_req[1:0]}), 0);
    pop_expect(0, 8'hC1, "R4 port0 old");
    pop_expect(0, 8'hC2, "R4 port0 new");
    pop_expect(1, 8'hD1, "R4 port1 old");
    pop_expect(1, 8'hD2, "R4 port1 new");
    drain();
    @(negedge clk); #1;
    chk(crd_avail == '1, "R3 credits restored", int'(crd_avail), 15);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule